// File: doc/BRIEF.md
# Bus Mode Detect Controller

This block is the digital control core of a multimode line terminator for a parallel bus that shares one three-level mode-sense line. Two analog comparators watch that line and report, as asynchronous flags, whether its voltage sits under the low threshold (about 0.6 V) or over the high threshold (about 2.15 V). The controller turns the pair of flags into one of three bus modes: single-ended, low-voltage differential or high-voltage differential. It adopts a new mode only after the decoded value has held for a programmable stability window, nominally 1.25 ms and configurable anywhere from 0.66 ms to 2.0 ms.

The outputs drive the analog parts of the terminator. One picks the 2.85 V or the 1.25 V reference. One switches in the single-ended parallel resistors. One grounds the positive-side line pins. The others isolate all termination pins, enable the reference regulator and enable the mode-sense driver. Two override inputs take precedence over the decoded mode. The isolate request keeps the reference running. A thermal fault switches the reference off. The isolate pin is expected to carry a pull-down at the pad, so that if it is left undriven it reads low and the bus stays terminated.

Top module: `bus_mode_ctrl`

## Requirements
- R1: The sense flags decode as follows: below-low set with above-high clear is single-ended; above-high set with below-low clear is high-voltage differential; both clear is low-voltage differential.
- R2: A decoded mode becomes the applied mode only after FILT_CYC consecutive clock cycles of the same decoded value at the filter; any different value in that window restarts the count, so a shorter run never changes the applied mode.
- R3: Both flags set at once counts as no change: it neither restarts the stability count nor replaces the pending mode, and the applied mode holds.
- R4: With low-voltage differential applied and no override, ref_hi_o=0, se_res_o=0, pgnd_o=0, pins_iso_o=0, ref_en_o=1 and sense_drv_o=1.
- R5: With single-ended applied and no override, ref_hi_o=1, se_res_o=1, pgnd_o=1, pins_iso_o=0, ref_en_o=1 and sense_drv_o=1.
- R6: With high-voltage differential applied and no override, pins_iso_o=1, se_res_o=0, pgnd_o=0, ref_hi_o=0 and ref_en_o=1.
- R7: With isolate_i high and no thermal fault, pins_iso_o=1, ref_en_o=1, sense_drv_o=0, se_res_o=0 and pgnd_o=0.
- R8: With thermal_i high, pins_iso_o=1, ref_en_o=0, sense_drv_o=0, ref_hi_o=0, se_res_o=0 and pgnd_o=0, whatever isolate_i and the mode are.
- R9: From reset until the first mode is applied, pins_iso_o=1, sense_drv_o=0, ref_en_o=1 and ref_hi_o=0; with both flags held clear from reset release, low-voltage differential is applied after FILT_CYC clock edges.
- R10: Every asynchronous input passes through two flip-flops, so a change on isolate_i or thermal_i appears at the outputs after the second rising clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_lo_i | input | 1 | Comparator flag: sense line below the low threshold (asynchronous) |
| sense_hi_i | input | 1 | Comparator flag: sense line above the high threshold (asynchronous) |
| isolate_i | input | 1 | Isolate request, pulled low at the pad (asynchronous) |
| thermal_i | input | 1 | Thermal fault from the temperature sensor (asynchronous) |
| ref_hi_o | output | 1 | 1 selects the 2.85 V reference, 0 the 1.25 V reference |
| se_res_o | output | 1 | Switch in the single-ended parallel resistors |
| pgnd_o | output | 1 | Ground the positive-side line pins |
| pins_iso_o | output | 1 | Isolate all termination pins from the bus |
| ref_en_o | output | 1 | Enable the reference regulator (0 puts it in high impedance) |
| sense_drv_o | output | 1 | Enable the mode-sense line driver |

## Verification
On every cycle the assertions check the rules of the stability filter. The counter never passes its terminal value. The applied mode changes only from a pending mode whose count has run out. A both-flags sample leaves the pending mode alone. They also check that the thermal and isolate overrides and the pre-decision state force isolation and the correct driver and reference enables, and that pin grounding never coexists with isolation. The timing cannot be seen by a single-cycle property, so only the bench scenarios show it: the exact edge on which a mode is adopted, that a run one cycle too short is discarded, that an invalid pair lets a pending mode finish its count, and the two-edge latency of the synchronizer.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    MD_LVD = 2'd0,
    MD_SE  = 2'd1,
    MD_HVD = 2'd2,
    MD_BAD = 2'd3
  } bus_mode_t;

  // Turns the two comparator flags into a bus mode.
  function automatic bus_mode_t decode_sense(input logic below_lo, input logic above_hi);
    case ({above_hi, below_lo})
      2'b00:   return MD_LVD;
      2'b01:   return MD_SE;
      2'b10:   return MD_HVD;
      default: return MD_BAD;
    endcase
  endfunction

  // Clock cycles in a window of the given number of microseconds.
  function automatic longint unsigned cycles_for_us(input longint unsigned clk_hz,
                                                    input longint unsigned us);
    return (clk_hz * us) / 64'd1000000;
  endfunction

endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= 1'b0;
        stab_q[b] <= 1'b0;
      end else begin
        meta_q[b] <= async_i[b];
        stab_q[b] <= meta_q[b];
      end
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/bmc_mode_filter.sv
module bmc_mode_filter
  import bmc_pkg::*;
#(
  parameter int FILT_CYC = 1250,
  parameter int CNT_W    = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      below_lo,
  input  logic      above_hi,
  output bus_mode_t applied_mode,
  output logic      applied_valid
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

  bus_mode_t        raw_mode;
  bus_mode_t        eff_mode;
  bus_mode_t        cand_q;
  logic [CNT_W-1:0] cnt_q;
  bus_mode_t        acc_q;
  logic             valid_q;

  // Named events for the assertions
  logic bad_pair;
  logic restart_ev;
  logic accept_ev;

  assign raw_mode   = decode_sense(below_lo, above_hi);
  assign bad_pair   = (raw_mode == MD_BAD);
  assign eff_mode   = bad_pair ? cand_q : raw_mode;
  assign restart_ev = (eff_mode != cand_q);
  assign accept_ev  = !restart_ev && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= MD_LVD;
      cnt_q   <= '0;
      acc_q   <= MD_LVD;
      valid_q <= 1'b0;
    end else if (restart_ev) begin
      cand_q <= eff_mode;
      cnt_q  <= '0;
    end else if (accept_ev) begin
      acc_q   <= cand_q;
      valid_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign applied_mode  = acc_q;
  assign applied_valid = valid_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_ACCEPT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) || (acc_q != $past(acc_q)) |-> ($past(cnt_q) == LAST && $past(cand_q) == acc_q)); // R2

  AST_BAD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pair |=> $stable(cand_q)); // R3

  AST_NEVER_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != MD_BAD && cand_q != MD_BAD); // R1
endmodule

// File: rtl/bmc_term_map.sv
module bmc_term_map
  import bmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_t mode,
  input  logic      mode_valid,
  input  logic      iso_req,
  input  logic      therm_flt,
  output logic      ref_hi,
  output logic      se_res,
  output logic      pgnd,
  output logic      pins_iso,
  output logic      ref_en,
  output logic      sense_drv
);
  always_comb begin
    ref_hi    = 1'b0;
    se_res    = 1'b0;
    pgnd      = 1'b0;
    pins_iso  = 1'b1;
    ref_en    = 1'b1;
    sense_drv = 1'b0;
    if (therm_flt) begin
      ref_en = 1'b0;
    end else if (iso_req || !mode_valid) begin
      ref_hi = mode_valid && (mode == MD_SE);
    end else begin
      sense_drv = 1'b1;
      case (mode)
        MD_LVD: pins_iso = 1'b0;
        MD_SE: begin
          pins_iso = 1'b0;
          ref_hi   = 1'b1;
          se_res   = 1'b1;
          pgnd     = 1'b1;
        end
        default: pins_iso = 1'b1;
      endcase
    end
  end

  AST_THERM_SHUTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    therm_flt |-> (pins_iso && !ref_en && !sense_drv)); // R8

  AST_ISO_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    iso_req |-> (pins_iso && !sense_drv && !pgnd)); // R7

  AST_PRE_DECISION_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid |-> (pins_iso && !sense_drv)); // R9

  AST_GROUND_NOT_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    pgnd |-> (!pins_iso && se_res && ref_hi)); // R5
endmodule

// File: rtl/bus_mode_ctrl.sv
module bus_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int CLK_HZ   = 1000000,
  parameter int FILT_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_lo_i,
  input  logic sense_hi_i,
  input  logic isolate_i,
  input  logic thermal_i,
  output logic ref_hi_o,
  output logic se_res_o,
  output logic pgnd_o,
  output logic pins_iso_o,
  output logic ref_en_o,
  output logic sense_drv_o
);
  localparam longint unsigned MAX_CYC = cycles_for_us(CLK_HZ, 2000);
  localparam int CNT_W = $clog2(MAX_CYC + 1) < 1 ? 1 : $clog2(MAX_CYC + 1);
  localparam int N_ASYNC = 4;

  logic [N_ASYNC-1:0] async_in;
  logic [N_ASYNC-1:0] sync_in;
  bus_mode_t          applied_mode;
  logic               applied_valid;

  assign async_in = {thermal_i, isolate_i, sense_hi_i, sense_lo_i};

  bmc_sync #(.W(N_ASYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_in),
    .sync_o  (sync_in)
  );

  bmc_mode_filter #(.FILT_CYC(FILT_CYC), .CNT_W(CNT_W)) u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .below_lo      (sync_in[0]),
    .above_hi      (sync_in[1]),
    .applied_mode  (applied_mode),
    .applied_valid (applied_valid)
  );

  bmc_term_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (applied_mode),
    .mode_valid (applied_valid),
    .iso_req    (sync_in[2]),
    .therm_flt  (sync_in[3]),
    .ref_hi     (ref_hi_o),
    .se_res     (se_res_o),
    .pgnd       (pgnd_o),
    .pins_iso   (pins_iso_o),
    .ref_en     (ref_en_o),
    .sense_drv  (sense_drv_o)
  );
endmodule

// File: tb/tb_bus_mode_ctrl.sv
module tb_bus_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, hi = 1'b0, iso = 1'b0, therm = 1'b0;
  logic ref_hi, se_res, pgnd, pins_iso, ref_en, drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_mode_ctrl #(.CLK_HZ(8000), .FILT_CYC(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .sense_lo_i(lo), .sense_hi_i(hi),
    .isolate_i(iso), .thermal_i(therm), .ref_hi_o(ref_hi), .se_res_o(se_res),
    .pgnd_o(pgnd), .pins_iso_o(pins_iso), .ref_en_o(ref_en), .sense_drv_o(drv));

  // Reference model: mode codes 0 = LVD, 1 = SE, 2 = HVD
  logic [3:0] dly[$];
  int m_pend, m_run, m_mode;
  bit m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly = '{4'b0, 4'b0};
      m_pend = 0; m_run = 0; m_mode = 0; m_ok = 0;
    end else begin
      logic [3:0] seen;
      int dec;
      seen = dly[0];
      if (seen[1:0] == 2'b11) dec = m_pend;
      else if (seen[0]) dec = 1;
      else if (seen[1]) dec = 2;
      else dec = 0;
      if (dec != m_pend) begin m_pend = dec; m_run = 0; end
      else if (m_run == FILT - 1) begin m_mode = m_pend; m_ok = 1; end
      else m_run++;
      void'(dly.pop_front());
      dly.push_back({therm, iso, hi, lo});
    end
  end

  task automatic cmp(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    logic e_hi, e_se, e_gnd, e_iso, e_en, e_drv;
    e_hi = 0; e_se = 0; e_gnd = 0; e_iso = 1; e_en = 1; e_drv = 0;
    if (dly[0][3]) e_en = 0;
    else if (dly[0][2] || !m_ok) e_hi = m_ok && m_mode == 1;
    else begin
      e_drv = 1;
      e_iso = (m_mode == 2);
      if (m_mode == 1) begin e_hi = 1; e_se = 1; e_gnd = 1; end
    end
    cmp("R4", "ref_hi", ref_hi, e_hi);
    cmp("R5", "se_res", se_res, e_se);
    cmp("R5", "pgnd", pgnd, e_gnd);
    cmp("R6", "pins_iso", pins_iso, e_iso);
    cmp("R8", "ref_en", ref_en, e_en);
    cmp("R7", "sense_drv", drv, e_drv);
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < WATCHDOG && !done; wd++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    edges(3);
    cmp("R9", "pins_iso in reset", pins_iso, 1'b1);
    cmp("R9", "sense_drv in reset", drv, 1'b0);
    rst_n = 1'b1;
    // R9: LVD applied after FILT edges with flags clear
    edges(FILT - 1);
    cmp("R9", "still isolated", pins_iso, 1'b1);
    cmp("R9", "ref_en before decision", ref_en, 1'b1);
    edges(1);
    cmp("R9", "LVD applied", pins_iso, 1'b0);
    cmp("R4", "LVD driver on", drv, 1'b1);
    // R1/R2: single-ended adopted exactly FILT+3 edges after the change
    lo = 1'b1;
    edges(FILT + 2);
    cmp("R2", "SE not yet", pgnd, 1'b0);
    edges(1);
    cmp("R1", "SE decoded", pgnd, 1'b1);
    cmp("R5", "SE reference", ref_hi, 1'b1);
    // R2: a run one cycle too short is discarded
    lo = 1'b0;
    edges(FILT + 5);
    cmp("R1", "back to LVD", pgnd, 1'b0);
    lo = 1'b1;
    edges(FILT);
    lo = 1'b0;
    edges(FILT + 8);
    cmp("R2", "short run ignored", pgnd, 1'b0);
    // R2: interruption restarts the window
    lo = 1'b1; edges(6); lo = 1'b0; edges(1); lo = 1'b1;
    edges(FILT + 2);
    cmp("R2", "restarted window", pgnd, 1'b0);
    edges(1);
    cmp("R2", "SE after restart", pgnd, 1'b1);
    // R3: invalid pair from LVD holds LVD
    lo = 1'b0; edges(FILT + 5);
    lo = 1'b1; hi = 1'b1; edges(3 * FILT);
    cmp("R3", "bad pair holds LVD", pgnd, 1'b0);
    cmp("R3", "bad pair keeps terminated", pins_iso, 1'b0);
    // R3: invalid pair does not restart a pending SE
    lo = 1'b0; hi = 1'b0; edges(FILT + 5);
    lo = 1'b1; edges(5); hi = 1'b1; edges(6);
    edges(2);
    cmp("R3", "pending SE completes", pgnd, 1'b1);
    hi = 1'b0;
    // R1/R6: high-voltage differential
    lo = 1'b0; hi = 1'b1;
    edges(FILT + 3);
    cmp("R6", "HVD isolated", pins_iso, 1'b1);
    cmp("R6", "HVD no ground", pgnd, 1'b0);
    hi = 1'b0; edges(FILT + 5);
    // R10/R7: isolate latency of two edges
    iso = 1'b1;
    edges(1);
    cmp("R10", "isolate after one edge", drv, 1'b1);
    edges(1);
    cmp("R7", "isolate driver off", drv, 1'b0);
    cmp("R7", "isolate keeps reference", ref_en, 1'b1);
    // R8: thermal overrides isolate
    therm = 1'b1;
    edges(1);
    cmp("R10", "thermal after one edge", ref_en, 1'b1);
    edges(1);
    cmp("R8", "thermal reference off", ref_en, 1'b0);
    iso = 1'b0; edges(4);
    cmp("R8", "thermal alone isolates", pins_iso, 1'b1);
    therm = 1'b0; edges(3);
    cmp("R4", "LVD restored", pins_iso, 1'b0);
    // Thermal while single-ended
    lo = 1'b1; edges(FILT + 4); therm = 1'b1; edges(2);
    cmp("R8", "thermal clears SE ground", pgnd, 1'b0);
    therm = 1'b0; edges(3);
    cmp("R5", "SE restored", pgnd, 1'b1);
    summary();
  end
endmodule